// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external serial master read and write a byte-wide register space with 14-bit addresses. The master lowers chip select and clocks in a 16-bit control word: a direction bit, a 14-bit start address, then a burst flag. Data bytes follow. A single access moves one byte. A burst access moves consecutive bytes for as long as the master keeps clocking, and the address wraps from the top of the space back to zero. Burst reads are prefetched one byte ahead.

The serial pins are sampled by the system clock. Each pin passes through a two-flop synchronizer, and the block detects edges on the synchronized clock. Two static inputs set the idle level of the serial clock and whether data is captured on the leading or the trailing edge. The topmost address is not passed to the register port. It holds an internal order byte, and setting either of two bits in that byte makes all later address fields and data bytes travel least significant bit first. The rest of the register space lives behind a simple parallel port with strobes.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, miso_oe, miso, reg_we and reg_re are all 0, and transfers use MSB-first order.
- R2: The control word occupies the first 16 serial bits after chip select falls. Slot 1 is the direction bit (1 = read, 0 = write). Slots 2 to 15 are the address, sent A13 first in MSB-first mode. Slot 16 is the burst flag (1 = burst).
- R3: A single write (burst = 0) produces exactly one reg_we pulse carrying the start address and the first data byte. Any further bytes in the same transaction are ignored.
- R4: A burst write produces one reg_we pulse per byte at consecutive addresses, and the address wraps from 3FFFh to 0000h.
- R5: A single read produces exactly one reg_re pulse at the start address. The byte returned on reg_rdata in that same cycle is shifted out on miso as the first data byte.
- R6: A burst read returns the bytes of consecutive addresses and wraps from 3FFFh to 0000h. The next byte is fetched while the current byte is being shifted out.
- R7: Address 3FFFh is an internal order byte and never strobes reg_we or reg_re. Bits 3 and 4 are stored, and reads return them in place with all other bits 0. If either bit is 1, transfers are LSB-first; if both are 0, transfers are MSB-first. A change applies from the next byte on.
- R8: In LSB-first mode the direction bit stays in slot 1 and the burst flag stays in slot 16. The 14 address bits arrive A0 first, and data bytes travel bit 0 first on both mosi and miso.
- R9: All four clock modes work. cpol gives the idle level of sck. With cpha = 0, mosi is captured on the leading edge and miso changes on the trailing edge. With cpha = 1, mosi is captured on the trailing edge and miso changes on the leading edge.
- R10: If chip select rises in the middle of a data byte, that byte is discarded with no reg_we pulse, and the next transaction starts cleanly.
- R11: miso_oe is 0 while chip select is inactive, during the control word and throughout a write. While it is 0, miso is 0.
- R12: reg_we and reg_re are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which samples the serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpol | input | 1 | Idle level of sck (static) |
| cpha | input | 1 | 0: capture on the leading edge; 1: capture on the trailing edge (static) |
| ss_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the miso pad driver |
| reg_addr | output | 14 | Register port address |
| reg_wdata | output | 8 | Register port write data |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_re | output | 1 | Read strobe, one cycle; reg_rdata is sampled in the same cycle |
| reg_rdata | input | 8 | Register port read data |

## Verification
A pin edge reaches the logic two system clocks later, and every result is registered once after that. So reg_we and a new miso bit appear three clocks after the sck edge that caused them. A read fetch is sampled in the cycle its strobe is high. The bench holds each sck half period for six clocks. It reads miso only at its own capture edge, at least six clocks after the shift edge that set the bit. It counts strobes and checks the logged addresses and data only after chip select has been high for six clocks. The master must therefore keep each sck half period at least five system clocks long.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int AW = 14,
  parameter int DW = 8,
  parameter int ORD_BIT_A = 3,
  parameter int ORD_BIT_B = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          ss_n,
  input  logic          sck,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CB = AW + 2;
  localparam int BW = $clog2(CB);
  localparam int TW = $clog2(DW);
  localparam logic [AW-1:0] TOP = '1;

  logic [2:0] sck_p;
  logic [1:0] ss_p, mosi_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0; ss_p <= 2'b11; mosi_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      ss_p <= {ss_p[0], ss_n};
      mosi_p <= {mosi_p[0], mosi};
    end

  wire sck_r  = sck_p[1] & ~sck_p[2];
  wire sck_f  = ~sck_p[1] & sck_p[2];
  wire lead   = cpol ? sck_f : sck_r;
  wire trail  = cpol ? sck_r : sck_f;
  wire active = ~ss_p[1];
  wire samp   = active & (cpha ? trail : lead);
  wire shft   = active & (cpha ? lead : trail);
  wire din    = mosi_p[1];

  logic [CB-2:0] ctrl_sr;
  logic [BW-1:0] bcnt;
  logic          in_data, rd_q, burst, done;
  logic [DW-1:0] rx_sr, tx_sr, pf;
  logic [TW-1:0] rx_cnt, tx_cnt;
  logic [AW-1:0] cur, addr_q, a_rev;
  logic [DW-1:0] wdata_q, ord_byte;
  logic [1:0]    ord;
  logic          w_q, f_q, f_top, oe_q, miso_q;

  wire          lsb    = |ord;
  wire [CB-1:0] cw     = {ctrl_sr, din};
  wire [AW-1:0] a_raw  = cw[CB-2:1];
  wire [AW-1:0] a_dec  = lsb ? a_rev : a_raw;
  wire [AW-1:0] cur_nx = cur + 1'b1;
  wire [DW-1:0] rx_nb  = lsb ? {din, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], din};

  always_comb
    for (int i = 0; i < AW; i++) a_rev[i] = a_raw[AW-1-i];

  always_comb begin
    ord_byte = '0;
    ord_byte[ORD_BIT_A] = ord[0];
    ord_byte[ORD_BIT_B] = ord[1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_sr <= '0; bcnt <= '0; in_data <= 1'b0; rd_q <= 1'b0; burst <= 1'b0;
      done <= 1'b0; rx_sr <= '0; tx_sr <= '0; pf <= '0; rx_cnt <= '0; tx_cnt <= '0;
      cur <= '0; addr_q <= '0; wdata_q <= '0; ord <= '0; w_q <= 1'b0;
      f_q <= 1'b0; f_top <= 1'b0; oe_q <= 1'b0; miso_q <= 1'b0;
    end else begin
      w_q <= 1'b0;
      f_q <= 1'b0;
      if (f_q) pf <= f_top ? ord_byte : reg_rdata;
      if (!active) begin
        bcnt <= '0; in_data <= 1'b0; done <= 1'b0;
        rx_cnt <= '0; tx_cnt <= '0; oe_q <= 1'b0;
      end else if (!in_data) begin
        if (samp) begin
          ctrl_sr <= cw[CB-2:0];
          bcnt <= bcnt + 1'b1;
          if (bcnt == BW'(CB - 1)) begin
            in_data <= 1'b1;
            rd_q <= cw[CB-1];
            burst <= cw[0];
            cur <= a_dec;
            if (cw[CB-1]) begin
              f_q <= 1'b1; f_top <= (a_dec == TOP); addr_q <= a_dec;
            end
          end
        end
      end else if (!rd_q) begin
        if (samp && !done) begin
          rx_sr <= rx_nb;
          rx_cnt <= (rx_cnt == TW'(DW - 1)) ? '0 : rx_cnt + 1'b1;
          if (rx_cnt == TW'(DW - 1)) begin
            if (cur == TOP) ord <= {rx_nb[ORD_BIT_B], rx_nb[ORD_BIT_A]};
            else begin
              w_q <= 1'b1; addr_q <= cur; wdata_q <= rx_nb;
            end
            cur <= cur_nx;
            if (!burst) done <= 1'b1;
          end
        end
      end else if (shft) begin
        if (done) oe_q <= 1'b0;
        else if (tx_cnt == '0) begin
          miso_q <= lsb ? pf[0] : pf[DW-1];
          tx_sr <= lsb ? (pf >> 1) : (pf << 1);
          tx_cnt <= TW'(DW - 1);
          oe_q <= 1'b1;
          if (burst) begin
            cur <= cur_nx; f_q <= 1'b1; f_top <= (cur_nx == TOP); addr_q <= cur_nx;
          end
        end else begin
          miso_q <= lsb ? tx_sr[0] : tx_sr[DW-1];
          tx_sr <= lsb ? (tx_sr >> 1) : (tx_sr << 1);
          tx_cnt <= tx_cnt - 1'b1;
          if (tx_cnt == TW'(1) && !burst) done <= 1'b1;
        end
      end
    end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = w_q;
  assign reg_re    = f_q & ~f_top;
  assign miso_oe   = oe_q;
  assign miso      = oe_q ? miso_q : 1'b0;

  assert_we_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  assert_re_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  assert_we_re_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  assert_we_only_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !rd_q);
  assert_re_only_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> rd_q);
  assert_top_internal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> reg_addr != TOP);
  assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_p[1] && $past(ss_p[1])) |-> !miso_oe);
  assert_oe_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> rd_q);
  assert_miso_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);
endmodule

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
  localparam int HP = 6;
  logic clk = 1'b0, rst_n = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, reg_we, reg_re;
  logic [13:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  spi_reg_slave uut (.clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .ss_n(ss_n),
    .sck(sck), .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata));

  function automatic logic [7:0] model(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction
  assign reg_rdata = model(reg_addr);

  int total = 0, fails = 0, wn = 0, rn = 0, oe_bad = 0, both_bad = 0;
  logic [13:0] wl_a [0:63];
  logic [7:0]  wl_d [0:63];
  logic [7:0]  wbuf [0:7];
  logic [7:0]  rbuf [0:7];
  bit lsb_m = 0, ctrl_ph = 0, wr_ph = 0, finished = 0;

  always @(posedge clk) begin
    if (reg_we) begin wl_a[wn[5:0]] <= reg_addr; wl_d[wn[5:0]] <= reg_wdata; wn <= wn + 1; end
    if (reg_re) rn <= rn + 1;
    if ((ctrl_ph || wr_ph) && miso_oe) oe_bad <= oe_bad + 1;
    if (reg_we && reg_re) both_bad <= both_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic sbit(input logic o, output logic i);
    if (!cpha) begin
      mosi = o; repeat (HP) @(negedge clk);
      sck = ~cpol; i = miso; repeat (HP) @(negedge clk);
      sck = cpol;
    end else begin
      sck = ~cpol; mosi = o; repeat (HP) @(negedge clk);
      sck = cpol; i = miso; repeat (HP) @(negedge clk);
    end
  endtask

  task automatic xact(input bit rd, input logic [13:0] a, input bit bu, input int nbits);
    logic o, x;
    ss_n = 1'b0; ctrl_ph = 1; repeat (HP) @(negedge clk);
    for (int s = 0; s < 16; s++) begin
      if (s == 0) o = rd;
      else if (s == 15) o = bu;
      else o = lsb_m ? a[s-1] : a[14-s];
      sbit(o, x);
    end
    ctrl_ph = 0; wr_ph = !rd;
    for (int k = 0; k < nbits; k++) begin
      int by = k / 8, j = k % 8;
      o = lsb_m ? wbuf[by][j] : wbuf[by][7-j];
      sbit(o, x);
      if (lsb_m) rbuf[by][j] = x; else rbuf[by][7-j] = x;
    end
    repeat (HP) @(negedge clk);
    ss_n = 1'b1; wr_ph = 0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    cpol = m[1]; cpha = m[0]; sck = m[1];
    repeat (HP) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    logic [13:0] a;
    repeat (3) @(negedge clk);
    chk(miso_oe == 0 && miso == 0, "R1 oe/miso after reset", {miso_oe, miso}, 0);
    chk(reg_we == 0 && reg_re == 0, "R1 strobes after reset", {reg_we, reg_re}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      a = 14'h0123 + 14'(m * 14'h0911);
      w0 = wn; wbuf[0] = 8'hA5 ^ 8'(m); wbuf[1] = 8'h3C;
      xact(0, a, 0, 16);
      chk(wn - w0 == 1, "R3 R9 single write count", wn - w0, 1);
      chk(wl_a[w0[5:0]] == a, "R2 R9 write address", wl_a[w0[5:0]], a);
      chk(wl_d[w0[5:0]] == wbuf[0], "R3 R9 write data", wl_d[w0[5:0]], wbuf[0]);
      a = 14'h2A57 - 14'(m * 14'h0333);
      r0 = rn; xact(1, a, 0, 8);
      chk(rbuf[0] == model(a), "R5 R9 single read data", rbuf[0], model(a));
      chk(rn - r0 == 1, "R5 single read strobe count", rn - r0, 1);
      chk(miso_oe == 0, "R11 oe after transaction", miso_oe, 0);
      a = 14'h1F00 + 14'(m * 14'h0047);
      w0 = wn;
      for (int k = 0; k < 3; k++) wbuf[k] = 8'(8'h10 * k + m + 1);
      xact(0, a, 1, 24);
      chk(wn - w0 == 3, "R4 R9 burst write count", wn - w0, 3);
      for (int k = 0; k < 3; k++) begin
        chk(wl_a[6'(w0 + k)] == a + 14'(k), "R4 burst write address", wl_a[6'(w0 + k)], a + 14'(k));
        chk(wl_d[6'(w0 + k)] == wbuf[k], "R4 burst write data", wl_d[6'(w0 + k)], wbuf[k]);
      end
      a = 14'h0C00 + 14'(m * 14'h0101);
      xact(1, a, 1, 24);
      for (int k = 0; k < 3; k++)
        chk(rbuf[k] == model(a + 14'(k)), "R6 R9 burst read data", rbuf[k], model(a + 14'(k)));
    end

    set_mode(0);
    w0 = wn; wbuf[0] = 8'h11; wbuf[1] = 8'h00; wbuf[2] = 8'h22;
    xact(0, 14'h3FFE, 1, 24);
    chk(wn - w0 == 2, "R4 R7 wrap write count", wn - w0, 2);
    chk(wl_a[w0[5:0]] == 14'h3FFE, "R4 wrap first address", wl_a[w0[5:0]], 14'h3FFE);
    chk(wl_a[6'(w0 + 1)] == 14'h0000, "R4 wrap to zero", wl_a[6'(w0 + 1)], 0);
    chk(wl_d[6'(w0 + 1)] == 8'h22, "R4 wrap data", wl_d[6'(w0 + 1)], 8'h22);
    xact(1, 14'h3FFE, 1, 24);
    chk(rbuf[0] == model(14'h3FFE), "R6 read before wrap", rbuf[0], model(14'h3FFE));
    chk(rbuf[1] == 8'h00, "R7 order byte in burst", rbuf[1], 0);
    chk(rbuf[2] == model(14'h0000), "R6 read after wrap", rbuf[2], model(14'h0000));

    w0 = wn; wbuf[0] = 8'hEE;
    xact(0, 14'h0055, 0, 5);
    chk(wn == w0, "R10 aborted byte not written", wn - w0, 0);
    wbuf[0] = 8'h77;
    xact(0, 14'h0056, 0, 8);
    chk(wn - w0 == 1 && wl_d[w0[5:0]] == 8'h77, "R10 clean restart", wl_d[w0[5:0]], 8'h77);

    w0 = wn; r0 = rn; wbuf[0] = 8'h08;
    xact(0, 14'h3FFF, 0, 8);
    chk(wn == w0, "R7 order write without strobe", wn - w0, 0);
    lsb_m = 1;
    w0 = wn; wbuf[0] = 8'h3C;
    xact(0, 14'h1234, 0, 8);
    chk(wl_a[w0[5:0]] == 14'h1234, "R8 reversed address", wl_a[w0[5:0]], 14'h1234);
    chk(wl_d[w0[5:0]] == 8'h3C, "R8 LSB-first write data", wl_d[w0[5:0]], 8'h3C);
    xact(1, 14'h0ABC, 0, 8);
    chk(rbuf[0] == model(14'h0ABC), "R8 LSB-first read data", rbuf[0], model(14'h0ABC));
    r0 = rn;
    xact(1, 14'h3FFF, 0, 8);
    chk(rbuf[0] == 8'h08, "R7 order byte readback", rbuf[0], 8'h08);
    chk(rn == r0, "R7 order read without strobe", rn - r0, 0);
    set_mode(3);
    xact(1, 14'h2001, 1, 16);
    chk(rbuf[0] == model(14'h2001) && rbuf[1] == model(14'h2002), "R8 R9 LSB burst read",
        rbuf[1], model(14'h2002));
    set_mode(0);
    wbuf[0] = 8'h10;
    xact(0, 14'h3FFF, 0, 8);
    xact(1, 14'h3FFF, 0, 8);
    chk(rbuf[0] == 8'h10, "R7 bit 4 keeps LSB-first", rbuf[0], 8'h10);
    wbuf[0] = 8'hE7;
    xact(0, 14'h3FFF, 0, 8);
    lsb_m = 0;
    xact(1, 14'h3FFF, 0, 8);
    chk(rbuf[0] == 8'h00, "R7 back to MSB-first", rbuf[0], 0);
    xact(1, 14'h0321, 0, 8);
    chk(rbuf[0] == model(14'h0321), "R2 MSB-first after switch", rbuf[0], model(14'h0321));

    chk(oe_bad == 0, "R11 oe during control or write", oe_bad, 0);
    chk(both_bad == 0, "R12 strobes overlap", both_bad, 0);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule